// File: doc/BRIEF.md
# Pin-Remapped Parallel-Capture Scan Chain

This block is a test-mode boundary chain for a memory die. It does not use a standard test access port. A dedicated scan enable pin latches the die into scan mode. After that, three shared pins take on scan roles: a capture/shift select, a scan clock and an active-low scan output enable. A shared strobe output pad also changes role and becomes the serial scan output. There are no instructions and no controller state machine. The only state is the mode latch and the chain itself.

The chain has one flop per observed signal. It also has a fixed number of reserved cells, which always capture zero. A rising scan clock with the select low loads the parallel levels into the chain. A rising scan clock with the select high moves the chain one place toward the output pad, and a constant zero enters at the head. The scan clock and the select are brought into the system clock domain through a synchroniser. Rising edges are then detected there. Once scan mode is set, only a power-on reset clears it.

Top module: `remap_scan_top`

## Requirements
- R1: After power-on reset, scan_mode_o is 0, every chain cell holds 0, and the strobe pad mirrors core_strobe_i and core_strobe_oe_i.
- R2: While scan mode has never been entered, the three shared pins pass straight through to core_rst_o, core_cs_n_o and core_cfg_o. Scan clock edges on shpin_b_i leave the chain unchanged.
- R3: scan_en_i high at a clock edge sets scan_mode_o at that edge. The mode stays set when scan_en_i falls, and only por_n low clears it.
- R4: In scan mode, the core-side shared outputs are forced inactive: core_rst_o=0, core_cs_n_o=1, core_cfg_o=0.
- R5: In scan mode, a rising edge on shpin_b_i with shpin_a_i low (capture) loads cell k with probe_i[k-N_RSV] for k>=N_RSV. The N_RSV reserved cells at the head (cells 0..N_RSV-1) load 0.
- R6: In scan mode, a rising edge on shpin_b_i with shpin_a_i high (shift) moves cell k-1 into cell k, and cell 0 loads 0.
- R7: The pad shows the last cell. After a capture, successive shifts present probe_i[N_SIG-1] down to probe_i[0], then N_RSV zeros, then zeros for ever.
- R8: In scan mode, strobe_pad_oe_o equals the inverse of shpin_c_i. Outside scan mode it equals core_strobe_oe_i.
- R9: The chain changes only on a synchronised rising scan clock. Holding the clock high, or moving the select while the clock is high, leaves it unchanged.
- R10: Scan clock and select reach the chain through SYNC_STAGES flops. The chain changes SYNC_STAGES+1 clock edges after the scan clock pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset |
| scan_en_i | input | 1 | Dedicated scan enable pin |
| shpin_a_i | input | 1 | Shared pin: reset in normal mode, capture(0)/shift(1) select in scan mode |
| shpin_b_i | input | 1 | Shared pin: chip select (active low) in normal mode, scan clock in scan mode |
| shpin_c_i | input | 1 | Shared pin: configuration in normal mode, active-low scan output enable in scan mode |
| probe_i | input | N_SIG | Parallel levels of the signals under test |
| core_strobe_i | input | 1 | Core data for the shared strobe pad |
| core_strobe_oe_i | input | 1 | Core drive enable for the shared strobe pad |
| core_rst_o | output | 1 | Shared pin A as seen by the core |
| core_cs_n_o | output | 1 | Shared pin B as seen by the core |
| core_cfg_o | output | 1 | Shared pin C as seen by the core |
| strobe_pad_o | output | 1 | Strobe pad data: core data, or last chain cell in scan mode |
| strobe_pad_oe_o | output | 1 | Strobe pad drive enable (0 = high impedance) |
| scan_mode_o | output | 1 | Sticky scan mode flag |

## Verification
Captures use three probe patterns. An alternating mixed word exposes swapped or misordered cells. A word with only the end bits set shows that both ends of the chain land correctly and that nothing leaks into the middle. An all-ones word makes the reserved cells and the zero fill at the head stand out, because any stray 1 there shows up as an extra bit. The probes are inverted just after each capture, so a chain that tracks live levels instead of captured ones is caught. Scan clock pulses given before scan mode is entered show whether they leak into the chain. A clock held high with the select changing shows whether level-triggered logic has replaced edge detection.

// File: rtl/remap_scan_pkg.sv
package remap_scan_pkg;

  typedef enum logic {
    OP_CAPTURE = 1'b0,
    OP_SHIFT   = 1'b1
  } scan_op_e;

  localparam logic IDLE_RST  = 1'b0;
  localparam logic IDLE_CS_N = 1'b1;
  localparam logic IDLE_CFG  = 1'b0;
  localparam logic HEAD_FILL = 1'b0;

  function automatic logic cell_next(input logic cap, input logic sh,
                                     input logic par, input logic pred,
                                     input logic cur);
    logic nxt;
    nxt = cur;
    if (cap)     nxt = par;
    else if (sh) nxt = pred;
    return nxt;
  endfunction

  function automatic logic rise_of(input logic now, input logic prev);
    return now & ~prev;
  endfunction

endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scan_mode_latch.sv
module scan_mode_latch (
  input  logic clk,
  input  logic por_n,
  input  logic en_i,
  output logic mode_o
);
  logic mode_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) mode_q <= 1'b0;
    else        mode_q <= mode_q | en_i;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/scan_pin_remap.sv
module scan_pin_remap
  import remap_scan_pkg::*;
(
  input  logic scan_mode,
  input  logic pin_a,
  input  logic pin_b,
  input  logic pin_c,
  input  logic core_strobe,
  input  logic core_strobe_oe,
  input  logic chain_tail,
  output logic core_rst,
  output logic core_cs_n,
  output logic core_cfg,
  output logic pad_o,
  output logic pad_oe
);
  always_comb begin
    if (scan_mode) begin
      core_rst  = IDLE_RST;
      core_cs_n = IDLE_CS_N;
      core_cfg  = IDLE_CFG;
      pad_o     = chain_tail;
      pad_oe    = ~pin_c;
    end else begin
      core_rst  = pin_a;
      core_cs_n = pin_b;
      core_cfg  = pin_c;
      pad_o     = core_strobe;
      pad_oe    = core_strobe_oe;
    end
  end
endmodule

// File: rtl/scan_cell.sv
module scan_cell
  import remap_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_i,
  input  logic sh_i,
  input  logic par_i,
  input  logic pred_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= cell_next(cap_i, sh_i, par_i, pred_i, q);
  end

  assign q_o = q;
endmodule

// File: rtl/scan_chain.sv
module scan_chain
  import remap_scan_pkg::*;
#(
  parameter int N_SIG = 16,
  parameter int N_RSV = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_evt,
  input  logic                   sh_evt,
  input  logic [N_SIG-1:0]       probe,
  output logic [N_SIG+N_RSV-1:0] chain_q
);
  localparam int L = N_SIG + N_RSV;

  function automatic logic [L-1:0] capture_vec(input logic [N_SIG-1:0] p);
    return {p, {N_RSV{1'b0}}};
  endfunction

  logic [L-1:0] par_vec;
  assign par_vec = capture_vec(probe);

  for (genvar k = 0; k < L; k++) begin : g_cell
    logic pred;
    if (k == 0) begin : g_head
      assign pred = HEAD_FILL;
    end else begin : g_body
      assign pred = chain_q[k-1];
    end
    scan_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (cap_evt),
      .sh_i   (sh_evt),
      .par_i  (par_vec[k]),
      .pred_i (pred),
      .q_o    (chain_q[k])
    );
  end
endmodule

// File: rtl/remap_scan_top.sv
module remap_scan_top
  import remap_scan_pkg::*;
#(
  parameter int N_SIG       = 16,
  parameter int N_RSV       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             scan_en_i,
  input  logic             shpin_a_i,
  input  logic             shpin_b_i,
  input  logic             shpin_c_i,
  input  logic [N_SIG-1:0] probe_i,
  input  logic             core_strobe_i,
  input  logic             core_strobe_oe_i,
  output logic             core_rst_o,
  output logic             core_cs_n_o,
  output logic             core_cfg_o,
  output logic             strobe_pad_o,
  output logic             strobe_pad_oe_o,
  output logic             scan_mode_o
);
  localparam int CHAIN_LEN = N_SIG + N_RSV;

  logic                 scan_mode;
  logic [1:0]           ctl_sync;
  logic                 sel_s;
  logic                 sck_s;
  logic                 sck_prev;
  logic                 sck_rise;
  logic                 cap_evt;
  logic                 sh_evt;
  logic [CHAIN_LEN-1:0] chain_q;
  logic                 chain_tail;

  scan_mode_latch u_mode (
    .clk    (clk),
    .por_n  (por_n),
    .en_i   (scan_en_i),
    .mode_o (scan_mode)
  );

  scan_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     ({shpin_a_i, shpin_b_i}),
    .q     (ctl_sync)
  );

  assign sel_s = ctl_sync[1];
  assign sck_s = ctl_sync[0];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  assign sck_rise = rise_of(sck_s, sck_prev);
  assign cap_evt  = scan_mode & sck_rise & (scan_op_e'(sel_s) == OP_CAPTURE);
  assign sh_evt   = scan_mode & sck_rise & (scan_op_e'(sel_s) == OP_SHIFT);

  scan_chain #(.N_SIG(N_SIG), .N_RSV(N_RSV)) u_chain (
    .clk     (clk),
    .rst_n   (por_n),
    .cap_evt (cap_evt),
    .sh_evt  (sh_evt),
    .probe   (probe_i),
    .chain_q (chain_q)
  );

  assign chain_tail = chain_q[CHAIN_LEN-1];

  scan_pin_remap u_remap (
    .scan_mode      (scan_mode),
    .pin_a          (shpin_a_i),
    .pin_b          (shpin_b_i),
    .pin_c          (shpin_c_i),
    .core_strobe    (core_strobe_i),
    .core_strobe_oe (core_strobe_oe_i),
    .chain_tail     (chain_tail),
    .core_rst       (core_rst_o),
    .core_cs_n      (core_cs_n_o),
    .core_cfg       (core_cfg_o),
    .pad_o          (strobe_pad_o),
    .pad_oe         (strobe_pad_oe_o)
  );

  assign scan_mode_o = scan_mode;
endmodule

// File: rtl/remap_scan_chk.sv
module remap_scan_chk #(
  parameter int L     = 18,
  parameter int N_RSV = 2
) (
  input logic         clk,
  input logic         por_n,
  input logic         scan_en_i,
  input logic         scan_mode_o,
  input logic         shpin_c_i,
  input logic         core_strobe_oe_i,
  input logic         core_rst_o,
  input logic         core_cs_n_o,
  input logic         core_cfg_o,
  input logic         strobe_pad_o,
  input logic         strobe_pad_oe_o,
  input logic         cap_evt,
  input logic         sh_evt,
  input logic [L-1:0] chain_q
);
  p_mode_entry_r3: assert property (@(posedge clk) disable iff (!por_n)
    scan_en_i |=> scan_mode_o);

  p_mode_sticky_r3: assert property (@(posedge clk) disable iff (!por_n)
    scan_mode_o |=> scan_mode_o);

  p_core_idle_r4: assert property (@(posedge clk) disable iff (!por_n)
    scan_mode_o |-> (!core_rst_o && core_cs_n_o && !core_cfg_o));

  p_no_evt_normal_r2: assert property (@(posedge clk) disable iff (!por_n)
    !scan_mode_o |-> !(cap_evt || sh_evt));

  p_events_exclusive_r9: assert property (@(posedge clk) disable iff (!por_n)
    !(cap_evt && sh_evt));

  p_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    !(cap_evt || sh_evt) |=> $stable(chain_q));

  p_capture_rsv_r5: assert property (@(posedge clk) disable iff (!por_n)
    cap_evt |=> (chain_q[N_RSV-1:0] == '0));

  p_shift_move_r6: assert property (@(posedge clk) disable iff (!por_n)
    sh_evt |=> (chain_q[0] == 1'b0) && (chain_q[L-1:1] == $past(chain_q[L-2:0])));

  p_pad_data_r7: assert property (@(posedge clk) disable iff (!por_n)
    scan_mode_o |-> (strobe_pad_o == chain_q[L-1]));

  p_pad_oe_scan_r8: assert property (@(posedge clk) disable iff (!por_n)
    scan_mode_o |-> (strobe_pad_oe_o == !shpin_c_i));

  p_pad_oe_normal_r8: assert property (@(posedge clk) disable iff (!por_n)
    !scan_mode_o |-> (strobe_pad_oe_o == core_strobe_oe_i));
endmodule

bind remap_scan_top remap_scan_chk #(.L(CHAIN_LEN), .N_RSV(N_RSV)) u_chk (
  .clk              (clk),
  .por_n            (por_n),
  .scan_en_i        (scan_en_i),
  .scan_mode_o      (scan_mode_o),
  .shpin_c_i        (shpin_c_i),
  .core_strobe_oe_i (core_strobe_oe_i),
  .core_rst_o       (core_rst_o),
  .core_cs_n_o      (core_cs_n_o),
  .core_cfg_o       (core_cfg_o),
  .strobe_pad_o     (strobe_pad_o),
  .strobe_pad_oe_o  (strobe_pad_oe_o),
  .cap_evt          (cap_evt),
  .sh_evt           (sh_evt),
  .chain_q          (chain_q)
);

// File: tb/test_remap_scan_top.sv
`timescale 1ns/1ps
module test_remap_scan_top;
  localparam int N_SIG = 16;
  localparam int N_RSV = 2;
  localparam int SYNC  = 2;
  localparam int L     = N_SIG + N_RSV;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic scan_en_i = 1'b0;
  logic shpin_a_i = 1'b0;
  logic shpin_b_i = 1'b0;
  logic shpin_c_i = 1'b0;
  logic [N_SIG-1:0] probe_i = '0;
  logic core_strobe_i = 1'b0;
  logic core_strobe_oe_i = 1'b0;
  logic core_rst_o, core_cs_n_o, core_cfg_o;
  logic strobe_pad_o, strobe_pad_oe_o, scan_mode_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  remap_scan_top #(.N_SIG(N_SIG), .N_RSV(N_RSV), .SYNC_STAGES(SYNC)) i_remap_scan_top (
    .clk(clk), .por_n(por_n), .scan_en_i(scan_en_i),
    .shpin_a_i(shpin_a_i), .shpin_b_i(shpin_b_i), .shpin_c_i(shpin_c_i),
    .probe_i(probe_i), .core_strobe_i(core_strobe_i), .core_strobe_oe_i(core_strobe_oe_i),
    .core_rst_o(core_rst_o), .core_cs_n_o(core_cs_n_o), .core_cfg_o(core_cfg_o),
    .strobe_pad_o(strobe_pad_o), .strobe_pad_oe_o(strobe_pad_oe_o), .scan_mode_o(scan_mode_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulse();
    @(negedge clk) shpin_b_i = 1'b1;
    wait_n(SYNC + 3);
    shpin_b_i = 1'b0;
    wait_n(SYNC + 3);
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk) shpin_a_i = v;
    wait_n(SYNC + 2);
  endtask

  task automatic t_reset();
    por_n = 1'b0;
    wait_n(3);
    @(negedge clk) por_n = 1'b1;
    core_strobe_i = 1'b1; core_strobe_oe_i = 1'b1;
    wait_n(1);
    chk("R1 mode after reset", 32'(scan_mode_o), 32'd0);
    chk("R1 pad data follows core", 32'(strobe_pad_o), 32'd1);
    chk("R1 pad oe follows core", 32'(strobe_pad_oe_o), 32'd1);
  endtask

  task automatic t_normal();
    @(negedge clk) shpin_a_i = 1'b1; shpin_b_i = 1'b0; shpin_c_i = 1'b1;
    #0.5;
    chk("R2 passthrough abc=101", {29'd0, core_rst_o, core_cs_n_o, core_cfg_o}, 32'b101);
    @(negedge clk) shpin_a_i = 1'b0; shpin_b_i = 1'b1; shpin_c_i = 1'b0;
    core_strobe_oe_i = 1'b0;
    #0.5;
    chk("R2 passthrough abc=010", {29'd0, core_rst_o, core_cs_n_o, core_cfg_o}, 32'b010);
    chk("R8 pad oe normal", 32'(strobe_pad_oe_o), 32'd0);
    @(negedge clk) shpin_b_i = 1'b0;
    probe_i = '1;
    set_sel(1'b0);
    sck_pulse();
    sck_pulse();
    chk("R2 no mode from sck", 32'(scan_mode_o), 32'd0);
  endtask

  task automatic t_enter();
    @(negedge clk) scan_en_i = 1'b1;
    @(negedge clk) scan_en_i = 1'b0;
    chk("R3 mode set", 32'(scan_mode_o), 32'd1);
    wait_n(10);
    chk("R3 mode sticky", 32'(scan_mode_o), 32'd1);
    @(negedge clk) shpin_a_i = 1'b1; shpin_b_i = 1'b0; shpin_c_i = 1'b1;
    #0.5;
    chk("R4 idle core outputs", {29'd0, core_rst_o, core_cs_n_o, core_cfg_o}, 32'b010);
    @(negedge clk) shpin_a_i = 1'b0; shpin_c_i = 1'b0;
    wait_n(SYNC + 2);
    chk("R2 chain untouched by earlier sck", 32'(strobe_pad_o), 32'd0);
  endtask

  task automatic t_capture_read(input logic [N_SIG-1:0] pat, input string tag);
    set_sel(1'b0);
    @(negedge clk) probe_i = pat;
    @(negedge clk) shpin_b_i = 1'b1;
    wait_n(SYNC);
    chk({"R10 no change before sync ", tag}, 32'(strobe_pad_o), 32'd0);
    wait_n(1);
    chk({"R10 captured at sync+1 ", tag}, 32'(strobe_pad_o), 32'(pat[N_SIG-1]));
    wait_n(SYNC + 2);
    shpin_b_i = 1'b0;
    probe_i = ~pat;
    wait_n(SYNC + 3);
    set_sel(1'b1);
    for (int i = 0; i < L + 3; i++) begin
      logic e;
      e = (i < N_SIG) ? pat[N_SIG-1-i] : 1'b0;
      if (i < N_SIG) chk({"R7 serial bit ", tag}, 32'(strobe_pad_o), 32'(e));
      else if (i < L) chk({"R5 reserved zero ", tag}, 32'(strobe_pad_o), 32'(e));
      else chk({"R6 zero fill ", tag}, 32'(strobe_pad_o), 32'(e));
      sck_pulse();
    end
  endtask

  task automatic t_oe();
    @(negedge clk) shpin_c_i = 1'b1;
    #0.5;
    chk("R8 scan oe off", 32'(strobe_pad_oe_o), 32'd0);
    @(negedge clk) shpin_c_i = 1'b0;
    #0.5;
    chk("R8 scan oe on", 32'(strobe_pad_oe_o), 32'd1);
  endtask

  task automatic t_hold();
    set_sel(1'b0);
    @(negedge clk) probe_i = 16'h8000;
    sck_pulse();
    chk("R5 capture msb", 32'(strobe_pad_o), 32'd1);
    @(negedge clk) shpin_a_i = 1'b1; shpin_b_i = 1'b1;
    wait_n(20);
    chk("R9 clock held high", 32'(strobe_pad_o), 32'd0);
    @(negedge clk) shpin_a_i = 1'b0;
    wait_n(10);
    chk("R9 select moves while high", 32'(strobe_pad_o), 32'd0);
    @(negedge clk) shpin_a_i = 1'b1;
    wait_n(10);
    shpin_b_i = 1'b0;
    wait_n(10);
    chk("R9 falling edge no effect", 32'(strobe_pad_o), 32'd0);
  endtask

  task automatic t_por_clear();
    @(negedge clk) por_n = 1'b0;
    wait_n(2);
    @(negedge clk) por_n = 1'b1;
    core_strobe_i = 1'b0; core_strobe_oe_i = 1'b1;
    wait_n(1);
    chk("R3 cleared by reset", 32'(scan_mode_o), 32'd0);
    chk("R1 pad follows core after reset", {30'd0, strobe_pad_o, strobe_pad_oe_o}, 32'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_enter();
    t_oe();
    t_capture_read(16'hA5C3, "A5C3");
    t_capture_read(16'h8001, "8001");
    t_capture_read(16'hFFFF, "FFFF");
    t_hold();
    t_por_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule